// File: doc/BRIEF.md
# Serial CRC-32 Frame Generator and Checker

This block computes the 32-bit Ethernet-class frame check sequence one bit at a time, for MAC designs running at low line rates. A single shift-register datapath does both jobs. In generate mode the block takes the payload of an outgoing frame and then shifts out the 32 check bits. In check mode it takes an incoming frame with its trailing check field and reports whether the frame arrived intact.

Each data bit is offered with a valid strobe. The first bit of a frame carries a start marker and the last bit carries an end marker. Bits may have idle gaps of any length between them. The mode input is captured together with the first bit of a frame and holds for the whole frame. In generate mode the check bits follow the end marker on consecutive clocks, flagged by an output valid. A done pulse follows the last check bit. In check mode, done and a pass/fail flag appear one clock after the end marker.

Top module: `crc32_serial_unit`

## Requirements
- R1: After reset, ser_vld, done and err are low. A bit offered with bit_vld but without sof while no frame is open is ignored, so no ser_vld and no done follow it.
- R2: The register uses the generator 0x04C11DB7 in normal form and is preset to all ones by sof. Data enters least significant bit of each byte first. The emitted check bits are the complemented register, from the x^31 term down to x^0. For the ASCII string "123456789", the n-th emitted bit is bit n of 0xCBF43926.
- R3: In generate mode, ser_vld is high for exactly 32 consecutive clocks. It starts on the clock after the edge that accepts the eof bit.
- R4: In generate mode, done pulses for one clock with err low on the clock after the last check bit. done is never high while ser_vld is high.
- R5: In check mode, done pulses on the clock after the eof bit is accepted. err is low when the frame (data plus its correct trailing check field) leaves the register at the residue 0xC704DD7B.
- R6: In check mode, a frame with any corrupted bit raises err together with done. err is never high without done.
- R7: In check mode, a frame of fewer than 32 bits gives err high with done. A 32-bit frame of all zeros (empty payload plus its check field) passes.
- R8: While bit_vld is low the register holds, so idle gaps between bits do not change the result.
- R9: While the check bits are being emitted, bit_vld, sof, eof and bit_in have no effect. The emitted sequence and the done timing are unchanged.
- R10: The mode is taken from mode_chk (0 generate, 1 check) on the sof bit. Changing mode_chk later in the frame has no effect.
- R11: A sof bit offered while a frame is open restarts the computation from the preset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Qualifies bit_in, sof and eof for this clock |
| bit_in | input | 1 | Serial data bit |
| sof | input | 1 | Marks the first bit of a frame |
| eof | input | 1 | Marks the last bit of a frame |
| mode_chk | input | 1 | 0 generate, 1 check; sampled with the sof bit |
| ser_out | output | 1 | Emitted check bit |
| ser_vld | output | 1 | ser_out carries a check bit |
| done | output | 1 | One-clock end-of-frame pulse |
| err | output | 1 | Check failed; valid with done |

## Verification
A wrong register bit in generate mode shows up as a wrong emitted check bit within 32 clocks after the eof bit. A reference CRC computed in reflected form catches it bit for bit. In check mode, the same fault shows up one clock after the eof bit as a wrong err value. Faults in the sequencer show as a ser_vld burst that is not exactly 32 clocks long, a missing or late done, or a reaction to inputs during emission or outside a frame. Each of these is visible within one frame.

// File: rtl/crc32_ser_pkg.sv
package crc32_ser_pkg;
  localparam int unsigned FCS_BITS    = 32;
  localparam logic [31:0] ETH_POLY    = 32'h04C1_1DB7;
  localparam logic [31:0] ETH_RESIDUE = 32'hC704_DD7B;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_EMIT = 2'd2
  } seq_state_e;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } unit_mode_e;
endpackage

// File: rtl/crc32_ser_lfsr.sv
// Shift register: preset, one feedback step per accepted bit, or a plain
// shift with feedback off while the check field is emitted.
module crc32_ser_lfsr #(
  parameter int unsigned W      = 32,
  parameter logic [W-1:0] POLY   = 32'h04C1_1DB7,
  parameter logic [W-1:0] PRESET = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         preset_i,
  input  logic         step_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o,
  output logic [W-1:0] stepped_o
);
  function automatic logic [W-1:0] lfsr_advance(input logic [W-1:0] cur,
                                                input logic din);
    logic fb;
    fb = cur[W-1] ^ din;
    return {cur[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
  endfunction

  logic [W-1:0] crc_q;
  logic [W-1:0] src;

  assign src       = preset_i ? PRESET : crc_q;
  assign stepped_o = lfsr_advance(src, bit_i);
  assign crc_o     = crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       crc_q <= PRESET;
    else if (step_i)  crc_q <= stepped_o;
    else if (shift_i) crc_q <= {crc_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/crc32_ser_ctl.sv
// Frame sequencer: accepts bits, tracks length and mode, runs emission.
module crc32_ser_ctl
  import crc32_ser_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld_i,
  input  logic sof_i,
  input  logic eof_i,
  input  logic mode_i,
  output logic step_o,
  output logic preset_o,
  output logic shift_o,
  output logic emitting_o,
  output logic chk_end_o,
  output logic emit_last_o,
  output logic short_o
);
  localparam int unsigned LW = $clog2(W + 1);
  localparam int unsigned EW = $clog2(W);

  seq_state_e state_q;
  unit_mode_e mode_q, eff_mode;
  logic [LW-1:0] len_q, len_next;
  logic [EW-1:0] emit_q;
  logic accept, start, finish;

  assign accept   = bit_vld_i && (state_q != ST_EMIT) && (sof_i || state_q == ST_DATA);
  assign start    = accept && sof_i;
  assign finish   = accept && eof_i;
  assign eff_mode = start ? unit_mode_e'(mode_i) : mode_q;

  always_comb begin
    if (start)                   len_next = LW'(1);
    else if (len_q == LW'(W))    len_next = len_q;
    else                         len_next = len_q + LW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_GEN;
      len_q   <= '0;
      emit_q  <= '0;
    end else begin
      if (accept) len_q <= len_next;
      if (start)  mode_q <= eff_mode;
      unique case (state_q)
        ST_IDLE, ST_DATA: begin
          if (finish) begin
            state_q <= (eff_mode == MODE_GEN) ? ST_EMIT : ST_IDLE;
            emit_q  <= '0;
          end else if (start) begin
            state_q <= ST_DATA;
          end
        end
        ST_EMIT: begin
          emit_q <= emit_q + EW'(1);
          if (emit_q == EW'(W - 1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign step_o      = accept;
  assign preset_o    = start;
  assign shift_o     = (state_q == ST_EMIT);
  assign emitting_o  = (state_q == ST_EMIT);
  assign chk_end_o   = finish && (eff_mode == MODE_CHK);
  assign emit_last_o = (state_q == ST_EMIT) && (emit_q == EW'(W - 1));
  assign short_o     = (len_next < LW'(W));
endmodule

// File: rtl/crc32_ser_status.sv
// Registers the end-of-frame verdict.
module crc32_ser_status #(
  parameter int unsigned  W       = 32,
  parameter logic [W-1:0] RESIDUE = 32'hC704_DD7B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chk_end_i,
  input  logic         emit_last_i,
  input  logic         short_i,
  input  logic [W-1:0] stepped_i,
  output logic         done_o,
  output logic         err_o
);
  function automatic logic residue_ok(input logic [W-1:0] value);
    return value == RESIDUE;
  endfunction

  logic bad_frame;
  assign bad_frame = short_i || !residue_ok(stepped_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= chk_end_i || emit_last_i;
      err_o  <= chk_end_i && bad_frame;
    end
  end
endmodule

// File: rtl/crc32_serial_unit.sv
module crc32_serial_unit
  import crc32_ser_pkg::*;
#(
  parameter int unsigned  W       = FCS_BITS,
  parameter logic [W-1:0] POLY    = ETH_POLY,
  parameter logic [W-1:0] RESIDUE = ETH_RESIDUE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic sof,
  input  logic eof,
  input  logic mode_chk,
  output logic ser_out,
  output logic ser_vld,
  output logic done,
  output logic err
);
  logic         step, preset, shift, emitting, chk_end, emit_last, short_frame;
  logic [W-1:0] crc, stepped;

  crc32_ser_ctl #(.W(W)) ctl_i (
    .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld), .sof_i(sof), .eof_i(eof),
    .mode_i(mode_chk), .step_o(step), .preset_o(preset), .shift_o(shift),
    .emitting_o(emitting), .chk_end_o(chk_end), .emit_last_o(emit_last),
    .short_o(short_frame)
  );

  crc32_ser_lfsr #(.W(W), .POLY(POLY), .PRESET({W{1'b1}})) lfsr_i (
    .clk(clk), .rst_n(rst_n), .preset_i(preset), .step_i(step),
    .shift_i(shift), .bit_i(bit_in), .crc_o(crc), .stepped_o(stepped)
  );

  crc32_ser_status #(.W(W), .RESIDUE(RESIDUE)) status_i (
    .clk(clk), .rst_n(rst_n), .chk_end_i(chk_end), .emit_last_i(emit_last),
    .short_i(short_frame), .stepped_i(stepped), .done_o(done), .err_o(err)
  );

  assign ser_vld = emitting;
  assign ser_out = emitting & ~crc[W-1];
endmodule

// File: rtl/crc32_serial_unit_chk.sv
module crc32_serial_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic ser_vld,
  input logic done,
  input logic err
);
  logic [5:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       run_q <= '0;
    else if (ser_vld) run_q <= run_q + 6'd1;
    else              run_q <= '0;
  end

  assert_err_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  assert_quiet_while_emit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ser_vld |-> !done);
  assert_emit_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_vld |-> run_q < 6'd32);
  assert_emit_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_vld) |-> run_q == 6'd32);
  assert_done_after_emit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_vld) |-> (done && !err));
endmodule

bind crc32_serial_unit crc32_serial_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ser_vld(ser_vld), .done(done), .err(err)
);

// File: tb/crc32_serial_unit_tb.sv
module crc32_serial_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n, bit_vld, bit_in, sof, eof, mode_chk;
  logic ser_out, ser_vld, done, err;
  int   n_cmp = 0, n_bad = 0;
  logic finished = 1'b0;
  logic fb [0:255];

  always #4 clk = ~clk;

  crc32_serial_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .sof(sof),
    .eof(eof), .mode_chk(mode_chk), .ser_out(ser_out), .ser_vld(ser_vld),
    .done(done), .err(err)
  );

  typedef struct packed {
    logic [31:0] data;
    logic [2:0]  nbytes;
    logic [1:0]  gap;
    logic        flip;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [0:NV-1] = '{
    '{32'h0000_0000, 3'd4, 2'd0, 1'b0},
    '{32'hFFFF_FFFF, 3'd4, 2'd2, 1'b0},
    '{32'h0000_00A7, 3'd1, 2'd0, 1'b1},
    '{32'hDEAD_BEEF, 3'd4, 2'd1, 1'b1},
    '{32'h0012_3456, 3'd3, 2'd3, 1'b0},
    '{32'h0000_55AA, 3'd2, 2'd0, 1'b1}
  };

  // Reference in reflected form: shift right, reflected polynomial.
  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] r;
    r = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      if (r[0] ^ fb[i]) r = (r >> 1) ^ 32'hEDB8_8320;
      else              r = r >> 1;
    end
    return ~r;
  endfunction

  task automatic expect_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    bit_vld = 1'b0; sof = 1'b0; eof = 1'b0; bit_in = 1'b0;
  endtask

  task automatic load_word(input logic [31:0] d, input int nbits);
    for (int i = 0; i < nbits; i++) fb[i] = d[i];
  endtask

  task automatic append_fcs(input int base, input logic [31:0] f);
    for (int i = 0; i < 32; i++) fb[base + i] = f[i];
  endtask

  task automatic send_frame(input int n, input int gap, input logic chk,
                            input logic flip_mode, input logic with_eof);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && (i % 3) == 1) repeat (gap) idle_cycle();
      @(negedge clk);
      bit_vld  = 1'b1;
      bit_in   = fb[i];
      sof      = (i == 0);
      eof      = with_eof && (i == n - 1);
      mode_chk = (flip_mode && i > 0) ? ~chk : chk;
    end
  endtask

  task automatic collect_fcs(input logic disturb, output logic [31:0] got,
                             output logic all_vld);
    all_vld = 1'b1;
    got     = '0;
    idle_cycle();
    for (int i = 0; i < 32; i++) begin
      all_vld = all_vld & ser_vld;
      got[i]  = ser_out;
      @(negedge clk);
      if (disturb && i < 31 && (i % 2) == 0) begin
        bit_vld = 1'b1; sof = 1'b1; eof = 1'b1; bit_in = 1'b1;
      end else begin
        bit_vld = 1'b0; sof = 1'b0; eof = 1'b0; bit_in = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, exp;
    logic        vld_ok;
    int          n;
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; sof = 1'b0; eof = 1'b0;
    mode_chk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    expect_eq("R1", "reset outputs", {29'd0, ser_vld, done, err}, 32'd0);

    // R1: bits without sof are ignored in both modes
    @(negedge clk); bit_vld = 1'b1; eof = 1'b1; bit_in = 1'b1; mode_chk = 1'b1;
    idle_cycle();
    expect_eq("R1", "no-sof check", {30'd0, done, ser_vld}, 32'd0);
    @(negedge clk); bit_vld = 1'b1; eof = 1'b1; bit_in = 1'b1; mode_chk = 1'b0;
    idle_cycle();
    expect_eq("R1", "no-sof gen", {30'd0, done, ser_vld}, 32'd0);

    // Vector table: generate, then check the frame with its field
    for (int v = 0; v < NV; v++) begin
      n = 8 * int'(VEC[v].nbytes);
      load_word(VEC[v].data, n);
      exp = ref_fcs(n);
      send_frame(n, int'(VEC[v].gap), 1'b0, 1'b0, 1'b1);
      collect_fcs(1'b0, got, vld_ok);
      expect_eq("R2", $sformatf("vec%0d fcs", v), got, exp);
      expect_eq("R3", $sformatf("vec%0d ser_vld run", v), {31'd0, vld_ok}, 32'd1);
      expect_eq("R4", $sformatf("vec%0d done/err/ser_vld", v),
                {29'd0, done, err, ser_vld}, 32'b100);
      append_fcs(n, got);
      if (VEC[v].flip) fb[5] = ~fb[5];
      send_frame(n + 32, int'(VEC[v].gap), 1'b1, 1'b0, 1'b1);
      idle_cycle();
      // R5 / R6 / R8: verdict one clock after eof, gaps included
      expect_eq(VEC[v].flip ? "R6" : "R5", $sformatf("vec%0d done/err", v),
                {30'd0, done, err}, {30'd0, 1'b1, VEC[v].flip});
    end

    // R2: known answer for "123456789"
    for (int k = 0; k < 9; k++)
      for (int j = 0; j < 8; j++) fb[8*k + j] = (8'h31 + k) >> j;
    send_frame(72, 0, 1'b0, 1'b0, 1'b1);
    collect_fcs(1'b0, got, vld_ok);
    expect_eq("R2", "known answer", got, 32'hCBF4_3926);

    // R7: short frame in check mode
    load_word(32'h0000_A5C3, 16);
    send_frame(16, 0, 1'b1, 1'b0, 1'b1);
    idle_cycle();
    expect_eq("R7", "short frame", {30'd0, done, err}, 32'b11);

    // R7: exactly 32 bits, empty payload plus its zero field
    load_word(32'h0, 32);
    send_frame(32, 0, 1'b1, 1'b0, 1'b1);
    idle_cycle();
    expect_eq("R7", "32-bit boundary", {30'd0, done, err}, 32'b10);

    // R9: inputs toggled during emission have no effect
    load_word(32'h1234_5678, 32);
    exp = ref_fcs(32);
    send_frame(32, 0, 1'b0, 1'b0, 1'b1);
    collect_fcs(1'b1, got, vld_ok);
    expect_eq("R9", "fcs under disturbance", got, exp);
    expect_eq("R9", "vld/done under disturbance", {30'd0, vld_ok, done}, 32'b11);
    idle_cycle();
    expect_eq("R4", "done one clock", {30'd0, done, ser_vld}, 32'd0);

    // R10: mode changed after sof is ignored (generate)
    load_word(32'hC0FF_EE11, 32);
    exp = ref_fcs(32);
    send_frame(32, 1, 1'b0, 1'b1, 1'b1);
    collect_fcs(1'b0, got, vld_ok);
    expect_eq("R10", "gen mode held", got, exp);
    expect_eq("R10", "gen emitted", {31'd0, vld_ok}, 32'd1);
    // R10: mode changed after sof is ignored (check)
    append_fcs(32, got);
    send_frame(64, 0, 1'b1, 1'b1, 1'b1);
    idle_cycle();
    expect_eq("R10", "chk mode held", {29'd0, done, err, ser_vld}, 32'b100);

    // R11: sof inside an open frame restarts the computation
    load_word(32'h000F_3A5C, 20);
    send_frame(20, 0, 1'b1, 1'b0, 1'b0);
    load_word(32'h8765_4321, 32);
    exp = ref_fcs(32);
    append_fcs(32, exp);
    send_frame(64, 0, 1'b1, 1'b0, 1'b1);
    idle_cycle();
    expect_eq("R11", "restart on sof", {30'd0, done, err}, 32'b10);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule